// File: doc/BRIEF.md
# Error-Protected Frame Word FIFO

This block is a synchronous first-in first-out store for frame words that pass between a memory-side mover and a line-side transmitter or receiver. Each entry carries a 32-bit data word, a 2-bit byte-valid code and a last-word-of-frame marker. These 35 payload bits are held together with 7 check bits in one 42-bit entry, and there are 1024 entries. The check bits form a single-error-correcting, double-error-detecting code. The code is a Hamming code over positions 1 to 41, with check bits at the power-of-two positions, plus one overall parity bit.

The check bits are computed on every write. On every read they are checked, and a single flipped bit is repaired. The read side works in show-ahead style: the oldest word is always on the read outputs while the FIFO is not empty, and a read strobe removes it. Two pulse outputs report a corrected error and an uncorrectable error, each in the cycle the affected word is removed. A check-enable input turns the checking on or off. Two injection inputs corrupt the word being written on purpose, so the status path can be tested.

Top module: `secded_frame_fifo`

## Requirements
- R1: Out of reset the FIFO is empty: `empty` is 1, `full` is 0, and both error pulses are 0.
- R2: Words are read in the order they were written. While `empty` is 0, the oldest word's data, byte-valid code and end marker appear on the read outputs. A clock edge with `rd_en` high and `empty` low removes that word.
- R3: After 1024 accepted writes with no reads, `full` is 1. A write while `full` is 1 is dropped: exactly 1024 words then read back, in order, and after them `empty` is 1.
- R4: A read strobe while `empty` is 1 has no effect. A word written afterwards is the first word read.
- R5: A write with `inj_single` high stores the word with data bit 0 inverted. When that word is removed with `ecc_en` high, the read data equals the written data, and `err_corr` is 1 in that removal cycle only.
- R6: A write with `inj_double` high stores the word with data bits 0 and 1 inverted. When that word is removed with `ecc_en` high, `err_uncorr` is 1 in that removal cycle, `err_corr` is 0, and the data is delivered as stored, with bits 0 and 1 still inverted.
- R7: With `ecc_en` low, the read outputs show the stored payload unrepaired, including any injected inversions, and both error pulses stay 0.
- R8: While `full` is 1, a cycle with both `wr_en` and `rd_en` high removes one word and accepts no write. While the FIFO is neither empty nor full, both strobes together remove one word and append one word.
- R9: If `inj_single` and `inj_double` are both high on a write, the double inversion (data bits 0 and 1) is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ecc_en | input | 1 | 1 enables checking and correction on read |
| inj_single | input | 1 | Invert data bit 0 of the word being written |
| inj_double | input | 1 | Invert data bits 0 and 1 of the word being written |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Data word to write |
| wr_be | input | 2 | Byte-valid code to write |
| wr_eof | input | 1 | End-of-frame marker to write |
| full | output | 1 | FIFO holds 1024 words |
| rd_en | input | 1 | Remove the oldest word |
| rd_data | output | 32 | Oldest word's data, corrected when enabled |
| rd_be | output | 2 | Oldest word's byte-valid code |
| rd_eof | output | 1 | Oldest word's end-of-frame marker |
| empty | output | 1 | FIFO holds no word |
| err_corr | output | 1 | Pulse: a single-bit error was repaired on this removal |
| err_uncorr | output | 1 | Pulse: an uncorrectable error was seen on this removal |

## Verification
The hardest condition to reach is a corrupted word that meets the decoder at the exact cycle of its removal. The word must also be read with a different `ecc_en` setting from the one in force when it was written, and this must happen in the middle of a pointer wrap. The stimulus reaches it through long random phases. These phases mix reads, writes and rare injections, and `ecc_en` changes per cycle, so corrupted words arrive at the head under both settings. A full fill and drain crosses the wrap point, with strobes driven at the full and empty edges. A behavioural queue records the injection applied to each word and predicts every output on every cycle.

// File: rtl/secded_frame_fifo.sv
module secded_frame_fifo #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 32,
  parameter int BE_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ecc_en,
  input  logic              inj_single,
  input  logic              inj_double,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BE_W-1:0]   wr_be,
  input  logic              wr_eof,
  output logic              full,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [BE_W-1:0]   rd_be,
  output logic              rd_eof,
  output logic              empty,
  output logic              err_corr,
  output logic              err_uncorr
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = DATA_W + BE_W + 1;

  function automatic int check_count(int pw);
    int r = 0;
    while ((1 << r) < pw + r + 1) r++;
    return r;
  endfunction

  localparam int HP = check_count(PW);
  localparam int N  = PW + HP;
  localparam int CW = N + 1;
  localparam int SW = HP;

  function automatic logic [CW-1:0] place(logic [PW-1:0] p);
    logic [CW-1:0] c = '0;
    int k = 0;
    for (int i = 1; i <= N; i++)
      if ((i & (i - 1)) != 0) begin
        c[i] = p[k];
        k++;
      end
    return c;
  endfunction

  function automatic logic [PW-1:0] extract(logic [CW-1:0] c);
    logic [PW-1:0] p = '0;
    int k = 0;
    for (int i = 1; i <= N; i++)
      if ((i & (i - 1)) != 0) begin
        p[k] = c[i];
        k++;
      end
    return p;
  endfunction

  function automatic logic [SW-1:0] syndrome(logic [CW-1:0] c);
    logic [SW-1:0] s = '0;
    for (int b = 0; b < HP; b++)
      for (int i = 1; i <= N; i++)
        if (((i >> b) & 1) == 1) s[b] = s[b] ^ c[i];
    return s;
  endfunction

  function automatic logic [CW-1:0] encode(logic [PW-1:0] p);
    logic [CW-1:0] c = place(p);
    logic [SW-1:0] s = syndrome(c);
    for (int b = 0; b < HP; b++) c[1 << b] = s[b];
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  logic [CW-1:0] mem [DEPTH];
  logic [AW:0]   wr_ptr, rd_ptr;
  logic          push, pop;
  logic [1:0]    flip;
  logic [CW-1:0] wr_code, rd_code, fixed;
  logic [SW-1:0] syn;
  logic          ovp, bad, corr;
  logic [PW-1:0] out_p;

  assign empty = (wr_ptr == rd_ptr);
  assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign push  = wr_en && !full;
  assign pop   = rd_en && !empty;

  assign flip    = inj_double ? 2'b11 : (inj_single ? 2'b01 : 2'b00);
  assign wr_code = encode({wr_eof, wr_be, wr_data}) ^ place({{(PW-2){1'b0}}, flip});

  always_ff @(posedge clk) if (push) mem[wr_ptr[AW-1:0]] <= wr_code;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
    end

  assign rd_code = mem[rd_ptr[AW-1:0]];
  assign syn     = syndrome(rd_code);
  assign ovp     = ^rd_code;
  assign bad     = (!ovp && syn != '0) || (ovp && int'(syn) > N);
  assign corr    = ovp && !bad;
  assign fixed   = corr ? (rd_code ^ (CW'(1) << syn)) : rd_code;
  assign out_p   = extract(ecc_en ? fixed : rd_code);

  assign rd_data    = out_p[DATA_W-1:0];
  assign rd_be      = out_p[DATA_W +: BE_W];
  assign rd_eof     = out_p[PW-1];
  assign err_corr   = pop && ecc_en && corr;
  assign err_uncorr = pop && ecc_en && bad;

  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n) !(full && empty));
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> (full && $stable(wr_ptr)));
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !wr_en) |=> (empty && $stable(rd_ptr)));
  assert_full_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && rd_en) |=> (!full && !empty));
  assert_err_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({err_corr, err_uncorr}));
  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ecc_en |-> (!err_corr && !err_uncorr));
  assert_err_on_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_corr || err_uncorr) |-> (rd_en && !empty));
endmodule

// File: tb/test_secded_frame_fifo.sv
module test_secded_frame_fifo;
  localparam int DEPTH = 1024;

  typedef struct packed {
    logic [31:0] d;
    logic [1:0]  be;
    logic        e;
    logic [1:0]  f;
  } ent_t;

  logic clk = 0, rst_n = 0;
  logic ecc_en = 1, inj_single = 0, inj_double = 0, wr_en = 0, rd_en = 0, wr_eof = 0;
  logic [31:0] wr_data = '0;
  logic [1:0]  wr_be = '0;
  logic full, empty, rd_eof, err_corr, err_uncorr;
  logic [31:0] rd_data;
  logic [1:0]  rd_be;

  int compared = 0, mismatched = 0;
  bit done = 0;
  string ph = "R2";
  ent_t q[$];

  always #4 clk = ~clk;

  secded_frame_fifo i_secded_frame_fifo (
    .clk, .rst_n, .ecc_en, .inj_single, .inj_double, .wr_en, .wr_data, .wr_be, .wr_eof,
    .full, .rd_en, .rd_data, .rd_be, .rd_eof, .empty, .err_corr, .err_uncorr);

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit w, bit r, bit ecc, bit s1, bit s2, logic [31:0] d, logic [1:0] be, bit e);
    int n;
    ent_t h;
    logic [31:0] xd;
    bit xc, xu;
    @(negedge clk);
    wr_en = w; rd_en = r; ecc_en = ecc; inj_single = s1; inj_double = s2;
    wr_data = d; wr_be = be; wr_eof = e;
    #1;
    n = q.size();
    chk("R4", "empty", empty, n == 0);
    chk("R3", "full", full, n == DEPTH);
    xc = 0; xu = 0;
    if (n > 0) begin
      h = q[0];
      xd = h.d ^ {30'b0, h.f};
      if (ecc && h.f == 2'b01) begin xd = h.d; xc = r; end
      if (ecc && h.f == 2'b11) xu = r;
      chk(ecc ? ph : "R7", "rd_data", rd_data, xd);
      chk(ph, "rd_be", rd_be, h.be);
      chk(ph, "rd_eof", rd_eof, h.e);
    end
    chk(ecc ? "R5" : "R7", "err_corr", err_corr, xc);
    chk(ecc ? "R6" : "R7", "err_uncorr", err_uncorr, xu);
    @(posedge clk);
    if (r && n > 0) void'(q.pop_front());
    if (w && n < DEPTH) q.push_back('{d, be, e, s2 ? 2'b11 : (s1 ? 2'b01 : 2'b00)});
  endtask

  task automatic rnd_step(int wp, int rp, bit ecc_rand);
    step(($urandom % 100) < wp, ($urandom % 100) < rp,
         ecc_rand ? ($urandom % 4 != 0) : 1'b1,
         ($urandom % 8) == 0, ($urandom % 12) == 0,
         $urandom, 2'($urandom), 1'($urandom));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "empty", empty, 1);
    chk("R1", "full", full, 0);
    chk("R1", "err_corr", err_corr, 0);
    chk("R1", "err_uncorr", err_uncorr, 0);
    @(negedge clk) rst_n = 1;
    // R4: reads on empty are ignored
    repeat (4) step(0, 1, 1, 0, 0, 0, 0, 0);
    step(1, 1, 1, 0, 0, 32'hCAFE_0001, 2'b10, 1);
    step(0, 1, 1, 0, 0, 0, 0, 0);
    // R5, R6, R9: directed injections
    ph = "R5"; step(1, 0, 1, 1, 0, 32'h1234_5678, 2'b01, 0);
    ph = "R6"; step(1, 0, 1, 0, 1, 32'h8765_4321, 2'b11, 1);
    ph = "R9"; step(1, 0, 1, 1, 1, 32'hFFFF_FFFC, 2'b00, 0);
    ph = "R5"; step(0, 1, 1, 0, 0, 0, 0, 0);
    ph = "R6"; step(0, 1, 1, 0, 0, 0, 0, 0);
    ph = "R9"; step(0, 1, 1, 0, 0, 0, 0, 0);
    // R7: same injections read with checking off
    ph = "R7";
    step(1, 0, 0, 1, 0, 32'hA5A5_A5A5, 2'b01, 1);
    step(1, 0, 0, 0, 1, 32'h5A5A_5A5A, 2'b10, 0);
    repeat (3) step(0, 1, 0, 0, 0, 0, 0, 0);
    // R2: random traffic with mixed ecc_en
    ph = "R2";
    repeat (3000) rnd_step(55, 50, 1);
    repeat (600) rnd_step(20, 90, 1);
    while (q.size() > 0) step(0, 1, 1, 0, 0, 0, 0, 0);
    // R3: fill past full
    ph = "R3";
    for (int i = 0; i < DEPTH + 6; i++) step(1, 0, 1, 0, 0, 32'h100 + i, 2'(i), 1'(i));
    // R8: both strobes while full
    ph = "R8";
    repeat (3) step(1, 1, 1, 0, 0, 32'hDEAD_0000, 2'b11, 1);
    repeat (2) step(1, 1, 1, 0, 0, 32'hBEEF_0000, 2'b01, 0);
    ph = "R3";
    while (q.size() > 0) step(0, 1, 1, 0, 0, 0, 0, 0);
    step(0, 1, 1, 0, 0, 0, 0, 0);
    ph = "R8";
    step(1, 0, 1, 0, 0, 32'h0000_0077, 2'b10, 0);
    repeat (40) step(1, 1, 1, 0, 0, $urandom, 2'b01, 1);
    while (q.size() > 0) step(0, 1, 1, 0, 0, 0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule